// File: doc/BRIEF.md
# Crossing Stub Frame Serialiser

This block takes the stubs found during one bunch crossing and turns them into a fixed 40-bit frame for that crossing. A stub is a 13-bit record: an 8-bit bottom-layer address at half-strip resolution and a 5-bit bend value. The bend value gives the position of the matching top-layer cluster inside its search window. Each frame holds three stub slots and one bit of triggered readout data. The frame is sent out over ten serial lanes. Each lane carries four bits per crossing, so the lanes run at four times the crossing rate.

The block runs on the fast clock, which is four times the crossing clock. A free-running slot counter splits every crossing into four slots. The stub inputs and the readout bit are sampled in the last slot of a crossing and sent during the next crossing. The first slot of each crossing is flagged by a frame marker. When more stubs are offered than fit in a frame, the three with the lowest addresses are kept and the others are counted in a running drop total. The block does not find stubs and does not receive frames.

Top module: `stub_frame_tx`

## Requirements
- R1: A kept stub occupies 13 adjacent frame bits: address in the upper 8 and bend in the lower 5. Slot j (j = 0, 1, 2) sits in frame bits [39-13j : 27-13j].
- R2: Kept stubs fill the slots in ascending address order. Equal addresses keep the lower input index first.
- R3: When more than three stubs are eligible, only the three with the lowest addresses are kept, using the tie rule of R2.
- R4: An input is eligible only when its valid flag is 1 and its address is non-zero. Any other input has no effect on the frame or on the drop total.
- R5: A slot with no stub carries an all-zero address and an all-zero bend. Address 0 therefore means an empty slot.
- R6: At each sampling point the drop total grows by the number of eligible stubs beyond three. It wraps at its width and does not change at any other time.
- R7: Transmit position k counts from 0 to 39, where position k is frame bit 39-k, so the most significant bit goes first. Position k appears on lane k mod 10 in slot k div 10.
- R8: The frame marker is 1 in slot 0 of every crossing and 0 in the other three slots.
- R9: Inputs present in slot 3 of a crossing are transmitted during the four slots of the next crossing.
- R10: While reset is asserted the slot counter is 0, the held frame is all zero (all lanes 0, marker 1), and the drop total is 0.
- R11: The triggered readout bit is frame bit 0, which is the last transmitted bit (lane 9, slot 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four slots per crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| stub_vld | input | N_IN | Per-input stub valid flags |
| stub_addr | input | N_IN*8 | Flattened stub addresses, input i at [8i+7:8i] |
| stub_bend | input | N_IN*5 | Flattened bend values, input i at [5i+4:5i] |
| ro_bit | input | 1 | Triggered readout data bit for this crossing |
| lane_out | output | 10 | Serial lanes, one frame bit per lane per slot |
| frame_mark | output | 1 | High during slot 0 of each crossing |
| drop_total | output | 16 | Wrapping count of dropped stubs |

## Verification
The bench targets tie-breaking among equal addresses. A selector that compares with <= instead of < would swap the bends of two tied stubs, and the lanes would show that swap. It offers inputs that are valid with address 0, and nonzero addresses that are not valid. A design that skipped either filter would take a slot or add to the drop total. Overflows with two and with three extra stubs check the drop arithmetic against slot capacity. Every frame is checked lane by lane over its four slots. A reversed bit order, a lane/slot transposition, or a one-crossing skew in capture would therefore show up as wrong lane words.

// File: rtl/stub_frame_pkg.sv
package stub_frame_pkg;

  // Frame bit carried by lane l in slot s (MSB-first striping).
  function automatic int stream_pos(int fw, int lanes, int s, int l);
    return fw - 1 - (s * lanes + l);
  endfunction

  // Stubs beyond the frame capacity.
  function automatic int excess(int eligible, int keep);
    return (eligible > keep) ? eligible - keep : 0;
  endfunction

endpackage

// File: rtl/stub_pick.sv
module stub_pick #(
  parameter int N_IN  = 6,
  parameter int KEEP  = 3,
  parameter int AW    = 8,
  parameter int BW    = 5,
  localparam int CNT_W = $clog2(N_IN + 1)
) (
  input  logic [N_IN-1:0]    vld,
  input  logic [N_IN*AW-1:0] addr_flat,
  input  logic [N_IN*BW-1:0] bend_flat,
  output logic [KEEP*AW-1:0] sel_addr,
  output logic [KEEP*BW-1:0] sel_bend,
  output logic [CNT_W-1:0]   n_elig
);

  logic [N_IN-1:0] elig;
  logic [N_IN-1:0] taken;
  logic            found;
  logic [AW-1:0]   best_a;
  int              best_i;

  for (genvar i = 0; i < N_IN; i++) begin : g_elig
    assign elig[i] = vld[i] && (addr_flat[i*AW +: AW] != '0);
  end

  assign n_elig = CNT_W'($countones(elig));

  // KEEP rounds of minimum search; strict < keeps the lowest index on ties.
  always_comb begin
    taken    = '0;
    sel_addr = '0;
    sel_bend = '0;
    found    = 1'b0;
    best_a   = '0;
    best_i   = 0;
    for (int j = 0; j < KEEP; j++) begin
      found  = 1'b0;
      best_a = '0;
      best_i = 0;
      for (int i = 0; i < N_IN; i++) begin
        if (elig[i] && !taken[i] && (!found || addr_flat[i*AW +: AW] < best_a)) begin
          found  = 1'b1;
          best_a = addr_flat[i*AW +: AW];
          best_i = i;
        end
      end
      if (found) begin
        taken[best_i]        = 1'b1;
        sel_addr[j*AW +: AW] = best_a;
        sel_bend[j*BW +: BW] = bend_flat[best_i*BW +: BW];
      end
    end
  end

endmodule

// File: rtl/frame_pack.sv
module frame_pack #(
  parameter int KEEP = 3,
  parameter int AW   = 8,
  parameter int BW   = 5,
  localparam int SW  = AW + BW,
  localparam int FW  = KEEP * SW + 1
) (
  input  logic [KEEP*AW-1:0] sel_addr,
  input  logic [KEEP*BW-1:0] sel_bend,
  input  logic               ro_bit,
  output logic [FW-1:0]      frame
);

  for (genvar j = 0; j < KEEP; j++) begin : g_slot
    assign frame[FW-1-j*SW -: AW]    = sel_addr[j*AW +: AW];
    assign frame[FW-1-j*SW-AW -: BW] = sel_bend[j*BW +: BW];
  end
  assign frame[0] = ro_bit;

endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import stub_frame_pkg::*;
#(
  parameter int FW    = 40,
  parameter int LANES = 10,
  localparam int SLOTS = FW / LANES,
  localparam int SLW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FW-1:0]    frame_d,
  output logic [LANES-1:0] lane_out,
  output logic             frame_mark,
  output logic             load
);

  logic [SLW-1:0]   slot_q;
  logic [FW-1:0]    frame_q;
  logic [LANES-1:0] slot_bits [SLOTS];

  assign load = (slot_q == SLW'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      frame_q <= '0;
    end else begin
      slot_q <= load ? '0 : slot_q + 1'b1;
      if (load) frame_q <= frame_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_s
    for (genvar l = 0; l < LANES; l++) begin : g_l
      assign slot_bits[s][l] = frame_q[stream_pos(FW, LANES, s, l)];
    end
  end

  assign lane_out   = slot_bits[slot_q];
  assign frame_mark = (slot_q == '0);

  // R8: marker lasts one slot and returns right after the last slot
  a_r8_mark_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> !frame_mark);
  a_r8_mark_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> frame_mark);
  // R9: held frame changes only at the crossing boundary
  a_r9_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(frame_q));

endmodule

// File: rtl/stub_frame_tx.sv
module stub_frame_tx
  import stub_frame_pkg::*;
#(
  parameter int N_IN   = 6,
  parameter int KEEP   = 3,
  parameter int AW     = 8,
  parameter int BW     = 5,
  parameter int LANES  = 10,
  parameter int DROP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    stub_vld,
  input  logic [N_IN*AW-1:0] stub_addr,
  input  logic [N_IN*BW-1:0] stub_bend,
  input  logic               ro_bit,
  output logic [LANES-1:0]   lane_out,
  output logic               frame_mark,
  output logic [DROP_W-1:0]  drop_total
);

  localparam int FW    = KEEP * (AW + BW) + 1;
  localparam int CNT_W = $clog2(N_IN + 1);

  logic [KEEP*AW-1:0] sel_addr;
  logic [KEEP*BW-1:0] sel_bend;
  logic [CNT_W-1:0]   n_elig;
  logic [FW-1:0]      frame_d;
  logic               load;
  logic [DROP_W-1:0]  drops_now;

  stub_pick #(.N_IN(N_IN), .KEEP(KEEP), .AW(AW), .BW(BW)) u_pick (
    .vld(stub_vld), .addr_flat(stub_addr), .bend_flat(stub_bend),
    .sel_addr(sel_addr), .sel_bend(sel_bend), .n_elig(n_elig)
  );

  frame_pack #(.KEEP(KEEP), .AW(AW), .BW(BW)) u_pack (
    .sel_addr(sel_addr), .sel_bend(sel_bend), .ro_bit(ro_bit), .frame(frame_d)
  );

  lane_serializer #(.FW(FW), .LANES(LANES)) u_ser (
    .clk(clk), .rst_n(rst_n), .frame_d(frame_d),
    .lane_out(lane_out), .frame_mark(frame_mark), .load(load)
  );

  assign drops_now = DROP_W'(excess(int'(n_elig), KEEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_total <= '0;
    else if (load) drop_total <= drop_total + drops_now;
  end

  // R6: total moves only at a sampling point that overflows
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(drop_total));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (load && n_elig <= CNT_W'(KEEP)) |=> $stable(drop_total));

  // R3: a full input set fills the last slot
  a_r3_full_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (n_elig >= CNT_W'(KEEP)) |-> (sel_addr[(KEEP-1)*AW +: AW] != '0));

  for (genvar j = 0; j < KEEP; j++) begin : g_chk
    // R5: empty slot carries no bend
    a_r5_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_addr[j*AW +: AW] == '0) |-> (sel_bend[j*BW +: BW] == '0));
    if (j + 1 < KEEP) begin : g_ord
      // R2: slots ascend and are packed from the front
      a_r2_sorted: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_addr[(j+1)*AW +: AW] != '0) |->
          (sel_addr[j*AW +: AW] != '0 &&
           sel_addr[j*AW +: AW] <= sel_addr[(j+1)*AW +: AW]));
    end
  end

endmodule

// File: tb/stub_frame_tx_bench.sv
module stub_frame_tx_bench;

  localparam int N_IN = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N_IN-1:0] stub_vld = '0;
  logic [47:0]     stub_addr = '0;
  logic [29:0]     stub_bend = '0;
  logic            ro_bit = 1'b0;
  logic [9:0]      lane_out;
  logic            frame_mark;
  logic [15:0]     drop_total;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_drops = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stub_frame_tx u_stub_frame_tx (
    .clk(clk), .rst_n(rst_n), .stub_vld(stub_vld), .stub_addr(stub_addr),
    .stub_bend(stub_bend), .ro_bit(ro_bit), .lane_out(lane_out),
    .frame_mark(frame_mark), .drop_total(drop_total)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_stub(int i, bit v, logic [7:0] a, logic [4:0] b);
    stub_vld[i]         = v;
    stub_addr[i*8 +: 8] = a;
    stub_bend[i*5 +: 5] = b;
  endtask

  task automatic clear_inputs();
    stub_vld = '0; stub_addr = '0; stub_bend = '0; ro_bit = 1'b0;
  endtask

  // Independent model: gather eligible stubs, stable insertion sort, pack.
  task automatic model(output logic [39:0] f, output int drops);
    logic [7:0] ka [N_IN];
    logic [4:0] kb [N_IN];
    int n = 0;
    for (int i = 0; i < N_IN; i++) begin
      if (stub_vld[i] && stub_addr[i*8 +: 8] != 8'd0) begin
        ka[n] = stub_addr[i*8 +: 8];
        kb[n] = stub_bend[i*5 +: 5];
        n++;
      end
    end
    for (int i = 1; i < n; i++) begin
      for (int p = i; p > 0 && ka[p-1] > ka[p]; p--) begin
        logic [7:0] ta; logic [4:0] tb;
        ta = ka[p]; ka[p] = ka[p-1]; ka[p-1] = ta;
        tb = kb[p]; kb[p] = kb[p-1]; kb[p-1] = tb;
      end
    end
    f = '0;
    for (int j = 0; j < 3 && j < n; j++) f[39-13*j -: 13] = {ka[j], kb[j]};
    f[0] = ro_bit;
    drops = (n > 3) ? n - 3 : 0;
  endtask

  // Called aligned at a slot-0 negedge with inputs set; returns aligned again.
  task automatic run_crossing(string tag);
    logic [39:0] f;
    logic [9:0]  expw [4];
    int d;
    model(f, d);
    for (int k = 0; k < 40; k++) expw[k / 10][k % 10] = f[39 - k];
    exp_drops = (exp_drops + d) % 65536;
    repeat (4) @(negedge clk);
    chk(frame_mark == 1'b1, {tag, " R8 marker slot0"}, 64'(frame_mark), 64'd1);
    chk(drop_total == 16'(exp_drops), {tag, " R6 drop total"}, 64'(drop_total), 64'(exp_drops));
    for (int s = 0; s < 4; s++) begin
      chk(lane_out == expw[s], $sformatf("%s R7 R9 lanes slot %0d", tag, s),
          64'(lane_out), 64'(expw[s]));
      if (s != 0)
        chk(frame_mark == 1'b0, {tag, " R8 marker low"}, 64'(frame_mark), 64'd0);
      if (s == 3) clear_inputs();
      @(negedge clk);
    end
  endtask

  task automatic t_single();
    set_stub(2, 1, 8'h5A, 5'h13); ro_bit = 1'b1;
    run_crossing("R1 R11 single stub");
  endtask

  task automatic t_order();
    set_stub(0, 1, 8'd200, 5'd1); set_stub(3, 1, 8'd17, 5'd2); set_stub(5, 1, 8'd90, 5'd3);
    run_crossing("R2 ascending order");
  endtask

  task automatic t_ties();
    set_stub(0, 1, 8'd40, 5'd7); set_stub(1, 1, 8'd10, 5'd21); set_stub(2, 1, 8'd40, 5'd9);
    set_stub(3, 1, 8'd250, 5'd4); set_stub(4, 1, 8'd10, 5'd30);
    run_crossing("R3 R2 overflow with ties");
  endtask

  task automatic t_ignore();
    set_stub(0, 0, 8'd3, 5'd31); set_stub(1, 1, 8'd0, 5'd17); set_stub(2, 0, 8'd1, 5'd5);
    set_stub(3, 1, 8'd0, 5'd1);  set_stub(4, 1, 8'd77, 5'd6); set_stub(5, 0, 8'd2, 5'd2);
    run_crossing("R4 ignored inputs");
  endtask

  task automatic t_empty();
    ro_bit = 1'b1;
    run_crossing("R5 R11 empty frame");
  endtask

  task automatic t_full();
    for (int i = 0; i < N_IN; i++) set_stub(i, 1, 8'(255 - i), 5'd31);
    run_crossing("R3 R6 all inputs");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lane_out == 10'd0, "R10 reset lanes", 64'(lane_out), 64'd0);
    chk(frame_mark == 1'b1, "R10 reset marker", 64'(frame_mark), 64'd1);
    chk(drop_total == 16'd0, "R10 reset drops", 64'(drop_total), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    while (!frame_mark) @(negedge clk);
    t_single();
    t_order();
    t_ties();
    t_ignore();
    t_empty();
    t_full();
    t_ties();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule